// File: doc/BRIEF.md
# MAC Address Learning and Lookup Table

This block keeps the station table of an Ethernet switch. Each MAC address maps to a slot in a direct-mapped main table. The slot index is a 10-bit hash of the address. When a new address hashes to a slot that already holds a different address, it goes into a small fully associative overflow store instead. A source-address learn request either refreshes an existing entry or stores a new one. A destination lookup searches both stores in the same cycle and returns the egress port, or reports a miss.

A background sweep walks every entry of both stores. Each entry carries a one-bit activity flag. On the first sweep visit after an entry was last seen, the flag is cleared. On the next visit the entry is removed if nothing set the flag again. Entries marked static are never changed by learning or aging. A management port reads and writes any entry of either store. A mode input shortens the sweep step, so entries expire in under a millisecond instead of about five minutes.

Top module: `mac_fwd_table`

## Requirements
- R1: The main-table index of an address is the XOR of all its IDX_W-bit chunks: bit i of the address is folded into index bit i mod IDX_W. A learned address whose slot is free is stored at that index.
- R2: A learned address whose main slot holds a different valid address is written to the lowest-numbered free overflow entry.
- R3: A lookup returns `res_valid` one cycle after `dst_valid`. The result is a hit if either store holds the address, and the port is taken from the store that holds it, the main table first. On a miss, `res_hit` and `res_port` are zero.
- R4: Learning never changes the port of a static entry, and aging never removes a static entry.
- R5: The management port writes the MAC, port, valid and static fields of any main entry (`mg_cam`=0) or overflow entry (`mg_cam`=1). A read returns those fields and the activity flag one cycle after the request.
- R6: If the main slot is taken by another address and every overflow entry is valid, the learn is dropped and `lrn_fail` is high for exactly the following cycle.
- R7: A sweep step happens every AGE_STEP_SLOW cycles, or every AGE_STEP_FAST cycles while `fast_age` is high. A step visits one entry, main table first and then the overflow store. A dynamic valid entry whose flag is set has the flag cleared; one whose flag is clear becomes invalid. The flag is set when an entry is learned, refreshed, found by a lookup, or written valid by management.
- R8: Learning an address already present in either store only updates its port and sets its flag. No second entry is created.
- R9: When a management write and a learn target the same entry in the same cycle, the management write decides the final contents.
- R10: After reset, every entry is invalid and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_age | input | 1 | Selects the short aging step |
| lrn_valid | input | 1 | Learn request |
| lrn_mac | input | MAC_W | Source address to learn |
| lrn_port | input | PORT_W | Ingress port of that address |
| lrn_fail | output | 1 | Learn dropped, both stores full |
| dst_valid | input | 1 | Lookup request |
| dst_mac | input | MAC_W | Destination address to look up |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | Address found |
| res_port | output | PORT_W | Egress port on a hit |
| mg_en | input | 1 | Management access |
| mg_we | input | 1 | 1 = write, 0 = read |
| mg_cam | input | 1 | 1 = overflow store, 0 = main table |
| mg_addr | input | IDX_W | Entry index (low bits for the overflow store) |
| mg_wmac | input | MAC_W | Write MAC |
| mg_wport | input | PORT_W | Write port |
| mg_wvalid | input | 1 | Write valid bit |
| mg_wstatic | input | 1 | Write static bit |
| mg_rmac | output | MAC_W | Read MAC |
| mg_rport | output | PORT_W | Read port |
| mg_rvalid | output | 1 | Read valid bit |
| mg_rstatic | output | 1 | Read static bit |
| mg_rage | output | 1 | Read activity flag |

## Verification
A learn and a management write can land on the same main-table entry in the same cycle. The bench drives a learn of one address and a management write of another address to the same slot on the same clock edge. It then expects a lookup of the written address to hit with the written port, and a management read of the slot to return the written MAC. The bench uses a 16-entry main table and a 4-entry overflow store, so it can fill every slot, saturate the overflow store with colliding addresses, and run complete aging passes within a short run.

// File: rtl/mtbl_pkg.sv
package mtbl_pkg;
   // index of the lowest set bit; 0 when none is set
   function automatic int unsigned first_one(input logic [63:0] v);
      int unsigned r;
      r = 0;
      for (int i = 63; i >= 0; i--) begin
         if (v[i]) r = i;
      end
      return r;
   endfunction
endpackage

// File: rtl/mtbl_hash.sv
module mtbl_hash #(
   parameter int MAC_W = 48,
   parameter int IDX_W = 10
) (
   input  logic [MAC_W-1:0] mac,
   output logic [IDX_W-1:0] idx
);
   if (MAC_W <= IDX_W) begin : g_pass
      assign idx = IDX_W'(mac);
   end else begin : g_fold
      always_comb begin
         idx = '0;
         for (int i = 0; i < MAC_W; i++) idx[i % IDX_W] = idx[i % IDX_W] ^ mac[i];
      end
   end
endmodule

// File: rtl/mtbl_cam_match.sv
module mtbl_cam_match #(
   parameter int MAC_W = 48,
   parameter int CAM_N = 16
) (
   input  logic [CAM_N-1:0]            vld,
   input  logic [CAM_N-1:0][MAC_W-1:0] keys,
   input  logic [MAC_W-1:0]            key,
   output logic [CAM_N-1:0]            hit
);
   for (genvar g = 0; g < CAM_N; g++) begin : g_cmp
      assign hit[g] = vld[g] && (keys[g] == key);
   end
endmodule

// File: rtl/mtbl_age_timer.sv
module mtbl_age_timer #(
   parameter int STEP_SLOW = 7_000_000,
   parameter int STEP_FAST = 19,
   parameter int N_ENT     = 1040
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     fast,
   output logic                     tick,
   output logic [$clog2(N_ENT)-1:0] ptr
);
   localparam int CNT_W = $clog2(STEP_SLOW + 1);
   localparam int PTR_W = $clog2(N_ENT);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] limit;

   assign limit = fast ? CNT_W'(STEP_FAST - 1) : CNT_W'(STEP_SLOW - 1);
   assign tick  = (cnt >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         ptr <= '0;
      end else if (tick) begin
         cnt <= '0;
         ptr <= (ptr == PTR_W'(N_ENT - 1)) ? '0 : ptr + 1'b1;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/mac_fwd_table.sv
module mac_fwd_table #(
   parameter int MAC_W         = 48,
   parameter int IDX_W         = 10,
   parameter int CAM_N         = 16,
   parameter int PORT_W        = 4,
   parameter int AGE_STEP_SLOW = 7_000_000,
   parameter int AGE_STEP_FAST = 19
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fast_age,
   input  logic              lrn_valid,
   input  logic [MAC_W-1:0]  lrn_mac,
   input  logic [PORT_W-1:0] lrn_port,
   output logic              lrn_fail,
   input  logic              dst_valid,
   input  logic [MAC_W-1:0]  dst_mac,
   output logic              res_valid,
   output logic              res_hit,
   output logic [PORT_W-1:0] res_port,
   input  logic              mg_en,
   input  logic              mg_we,
   input  logic              mg_cam,
   input  logic [IDX_W-1:0]  mg_addr,
   input  logic [MAC_W-1:0]  mg_wmac,
   input  logic [PORT_W-1:0] mg_wport,
   input  logic              mg_wvalid,
   input  logic              mg_wstatic,
   output logic [MAC_W-1:0]  mg_rmac,
   output logic [PORT_W-1:0] mg_rport,
   output logic              mg_rvalid,
   output logic              mg_rstatic,
   output logic              mg_rage
);
   import mtbl_pkg::*;

   localparam int DEPTH = 1 << IDX_W;
   localparam int CAM_W = $clog2(CAM_N);
   localparam int N_ENT = DEPTH + CAM_N;
   localparam int PTR_W = $clog2(N_ENT);

   if (CAM_N < 2 || CAM_N > 64 || (1 << CAM_W) != CAM_N || CAM_N > DEPTH) begin : g_bad_cam
      $error("CAM_N must be a power of two in 2..64 and no larger than the main table");
   end
   if (AGE_STEP_FAST < 1 || AGE_STEP_FAST > AGE_STEP_SLOW) begin : g_bad_age
      $error("aging steps must satisfy 1 <= AGE_STEP_FAST <= AGE_STEP_SLOW");
   end
   if (PORT_W < 1 || IDX_W < 1) begin : g_bad_w
      $error("PORT_W and IDX_W must be positive");
   end

   // storage
   logic [DEPTH-1:0]            m_vld, m_stat, m_age;
   logic [MAC_W-1:0]            m_mac  [DEPTH];
   logic [PORT_W-1:0]           m_port [DEPTH];
   logic [CAM_N-1:0]            c_vld, c_stat, c_age;
   logic [CAM_N-1:0][MAC_W-1:0] c_mac;
   logic [PORT_W-1:0]           c_port [CAM_N];

   // learn side decode
   logic [IDX_W-1:0] l_idx;
   logic [CAM_N-1:0] l_chit;
   logic             l_mhit, l_cany, l_fany;
   logic [CAM_W-1:0] l_csel, l_fsel;
   logic             l_main_new, l_main_ref, l_cam_new, l_cam_ref, l_fail;

   mtbl_hash #(.MAC_W(MAC_W), .IDX_W(IDX_W)) i_lhash (.mac(lrn_mac), .idx(l_idx));
   mtbl_cam_match #(.MAC_W(MAC_W), .CAM_N(CAM_N)) i_lcam (
      .vld(c_vld), .keys(c_mac), .key(lrn_mac), .hit(l_chit));

   always_comb begin
      l_mhit     = m_vld[l_idx] && (m_mac[l_idx] == lrn_mac);
      l_cany     = |l_chit;
      l_fany     = |(~c_vld);
      l_csel     = CAM_W'(first_one(64'(l_chit)));
      l_fsel     = CAM_W'(first_one(64'(~c_vld)));
      l_main_ref = lrn_valid && l_mhit && !m_stat[l_idx];
      l_cam_ref  = lrn_valid && !l_mhit && l_cany && !c_stat[l_csel];
      l_main_new = lrn_valid && !l_mhit && !l_cany && !m_vld[l_idx];
      l_cam_new  = lrn_valid && !l_mhit && !l_cany && m_vld[l_idx] && l_fany;
      l_fail     = lrn_valid && !l_mhit && !l_cany && m_vld[l_idx] && !l_fany;
   end

   // lookup side decode
   logic [IDX_W-1:0] q_idx;
   logic [CAM_N-1:0] q_chit;
   logic             q_mhit, q_cany;
   logic [CAM_W-1:0] q_csel;

   mtbl_hash #(.MAC_W(MAC_W), .IDX_W(IDX_W)) i_qhash (.mac(dst_mac), .idx(q_idx));
   mtbl_cam_match #(.MAC_W(MAC_W), .CAM_N(CAM_N)) i_qcam (
      .vld(c_vld), .keys(c_mac), .key(dst_mac), .hit(q_chit));

   always_comb begin
      q_mhit = dst_valid && m_vld[q_idx] && (m_mac[q_idx] == dst_mac);
      q_cany = dst_valid && (|q_chit);
      q_csel = CAM_W'(first_one(64'(q_chit)));
   end

   // aging sweep
   logic             tick, sw_main;
   logic [PTR_W-1:0] ptr, ptr_c;
   logic [IDX_W-1:0] sw_m;
   logic [CAM_W-1:0] sw_c;

   mtbl_age_timer #(.STEP_SLOW(AGE_STEP_SLOW), .STEP_FAST(AGE_STEP_FAST), .N_ENT(N_ENT))
      i_age (.clk(clk), .rst_n(rst_n), .fast(fast_age), .tick(tick), .ptr(ptr));

   assign sw_main = (ptr < PTR_W'(DEPTH));
   assign ptr_c   = ptr - PTR_W'(DEPTH);
   assign sw_m    = ptr[IDX_W-1:0];
   assign sw_c    = ptr_c[CAM_W-1:0];

   // management decode
   logic             mg_wr_m, mg_wr_c, mg_rd;
   logic [CAM_W-1:0] mg_ca;
   assign mg_wr_m = mg_en && mg_we && !mg_cam;
   assign mg_wr_c = mg_en && mg_we && mg_cam;
   assign mg_rd   = mg_en && !mg_we;
   assign mg_ca   = mg_addr[CAM_W-1:0];

   // control bits: sweep, then hit refresh, then learn, then management
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_vld <= '0; m_stat <= '0; m_age <= '0;
         c_vld <= '0; c_stat <= '0; c_age <= '0;
      end else begin
         if (tick) begin
            if (sw_main) begin
               if (m_vld[sw_m] && !m_stat[sw_m]) begin
                  if (m_age[sw_m]) m_age[sw_m] <= 1'b0;
                  else             m_vld[sw_m] <= 1'b0;
               end
            end else if (c_vld[sw_c] && !c_stat[sw_c]) begin
               if (c_age[sw_c]) c_age[sw_c] <= 1'b0;
               else             c_vld[sw_c] <= 1'b0;
            end
         end
         if (q_mhit)      m_age[q_idx]  <= 1'b1;
         else if (q_cany) c_age[q_csel] <= 1'b1;
         if (l_main_new) begin
            m_vld[l_idx] <= 1'b1; m_stat[l_idx] <= 1'b0; m_age[l_idx] <= 1'b1;
         end
         if (l_main_ref) m_age[l_idx] <= 1'b1;
         if (l_cam_new) begin
            c_vld[l_fsel] <= 1'b1; c_stat[l_fsel] <= 1'b0; c_age[l_fsel] <= 1'b1;
         end
         if (l_cam_ref) c_age[l_csel] <= 1'b1;
         if (mg_wr_m) begin
            m_vld[mg_addr] <= mg_wvalid; m_stat[mg_addr] <= mg_wstatic;
            m_age[mg_addr] <= mg_wvalid;
         end
         if (mg_wr_c) begin
            c_vld[mg_ca] <= mg_wvalid; c_stat[mg_ca] <= mg_wstatic;
            c_age[mg_ca] <= mg_wvalid;
         end
      end
   end

   // payload fields
   always_ff @(posedge clk) begin
      if (l_main_new) m_mac[l_idx] <= lrn_mac;
      if (l_main_new || l_main_ref) m_port[l_idx] <= lrn_port;
      if (l_cam_new) begin
         c_mac[l_fsel]  <= lrn_mac;
         c_port[l_fsel] <= lrn_port;
      end
      if (l_cam_ref) c_port[l_csel] <= lrn_port;
      if (mg_wr_m) begin
         m_mac[mg_addr]  <= mg_wmac;
         m_port[mg_addr] <= mg_wport;
      end
      if (mg_wr_c) begin
         c_mac[mg_ca]  <= mg_wmac;
         c_port[mg_ca] <= mg_wport;
      end
   end

   // registered outputs
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lrn_fail <= 1'b0;
         res_valid <= 1'b0; res_hit <= 1'b0; res_port <= '0;
         mg_rmac <= '0; mg_rport <= '0; mg_rvalid <= 1'b0;
         mg_rstatic <= 1'b0; mg_rage <= 1'b0;
      end else begin
         lrn_fail  <= l_fail;
         res_valid <= dst_valid;
         res_hit   <= q_mhit || q_cany;
         res_port  <= q_mhit ? m_port[q_idx] : (q_cany ? c_port[q_csel] : '0);
         if (mg_rd) begin
            if (mg_cam) begin
               mg_rmac <= c_mac[mg_ca]; mg_rport <= c_port[mg_ca];
               mg_rvalid <= c_vld[mg_ca]; mg_rstatic <= c_stat[mg_ca];
               mg_rage <= c_age[mg_ca];
            end else begin
               mg_rmac <= m_mac[mg_addr]; mg_rport <= m_port[mg_addr];
               mg_rvalid <= m_vld[mg_addr]; mg_rstatic <= m_stat[mg_addr];
               mg_rage <= m_age[mg_addr];
            end
         end
      end
   end
endmodule

// File: rtl/mtbl_checker.sv
module mtbl_checker #(
   parameter int DEPTH  = 1024,
   parameter int PORT_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lrn_valid,
   input logic              lrn_fail,
   input logic              dst_valid,
   input logic              res_valid,
   input logic              res_hit,
   input logic [PORT_W-1:0] res_port,
   input logic              mg_wr,
   input logic [DEPTH-1:0]  m_vld,
   input logic [DEPTH-1:0]  m_stat
);
   AST_RES_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      dst_valid |=> res_valid); // R3
   AST_NO_SPURIOUS_RES: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(dst_valid)); // R3
   AST_HIT_NEEDS_RES: assert property (@(posedge clk) disable iff (!rst_n)
      res_hit |-> res_valid); // R3
   AST_MISS_PORT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_hit) |-> (res_port == '0)); // R3
   AST_FAIL_NEEDS_LEARN: assert property (@(posedge clk) disable iff (!rst_n)
      lrn_fail |-> $past(lrn_valid)); // R6
   AST_STATIC_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(mg_wr) |-> (($past(m_vld & m_stat) & ~m_vld) == '0)); // R4
endmodule

bind mac_fwd_table mtbl_checker #(.DEPTH(DEPTH), .PORT_W(PORT_W)) i_mtbl_checker (
   .clk(clk), .rst_n(rst_n), .lrn_valid(lrn_valid), .lrn_fail(lrn_fail),
   .dst_valid(dst_valid), .res_valid(res_valid), .res_hit(res_hit),
   .res_port(res_port), .mg_wr(mg_en & mg_we), .m_vld(m_vld), .m_stat(m_stat));

// File: tb/test_mac_fwd_table.sv
module test_mac_fwd_table;
   localparam int CLK_P  = 10;
   localparam int MAC_W  = 48;
   localparam int IDX_W  = 4;
   localparam int CAM_N  = 4;
   localparam int PORT_W = 4;
   localparam int DEPTH  = 1 << IDX_W;

   logic clk = 1'b0, rst_n = 1'b0, fast_age = 1'b0;
   logic lrn_valid = 1'b0, dst_valid = 1'b0;
   logic [MAC_W-1:0] lrn_mac = '0, dst_mac = '0, mg_wmac = '0;
   logic [PORT_W-1:0] lrn_port = '0, mg_wport = '0;
   logic lrn_fail, res_valid, res_hit;
   logic [PORT_W-1:0] res_port, mg_rport;
   logic mg_en = 1'b0, mg_we = 1'b0, mg_cam = 1'b0, mg_wvalid = 1'b0, mg_wstatic = 1'b0;
   logic [IDX_W-1:0] mg_addr = '0;
   logic [MAC_W-1:0] mg_rmac;
   logic mg_rvalid, mg_rstatic, mg_rage;

   int checks = 0, errors = 0;
   bit done = 0;

   always #(CLK_P/2) clk = ~clk;

   mac_fwd_table #(.MAC_W(MAC_W), .IDX_W(IDX_W), .CAM_N(CAM_N), .PORT_W(PORT_W),
      .AGE_STEP_SLOW(1_000_000), .AGE_STEP_FAST(3)) i_mac_fwd_table (
      .clk(clk), .rst_n(rst_n), .fast_age(fast_age),
      .lrn_valid(lrn_valid), .lrn_mac(lrn_mac), .lrn_port(lrn_port), .lrn_fail(lrn_fail),
      .dst_valid(dst_valid), .dst_mac(dst_mac), .res_valid(res_valid), .res_hit(res_hit),
      .res_port(res_port), .mg_en(mg_en), .mg_we(mg_we), .mg_cam(mg_cam), .mg_addr(mg_addr),
      .mg_wmac(mg_wmac), .mg_wport(mg_wport), .mg_wvalid(mg_wvalid), .mg_wstatic(mg_wstatic),
      .mg_rmac(mg_rmac), .mg_rport(mg_rport), .mg_rvalid(mg_rvalid),
      .mg_rstatic(mg_rstatic), .mg_rage(mg_rage));

   // address whose chunk fold equals slot: the two tag copies cancel
   function automatic logic [MAC_W-1:0] mk(input logic [3:0] slot, input logic [7:0] tag);
      return {24'h0A0B0C ^ 24'h0A0B0C, tag, tag, 4'h0, slot} | 48'h5A5A_0000_0000 ^ 48'h5A5A_0000_0000;
   endfunction

   function automatic logic [IDX_W-1:0] fold(input logic [MAC_W-1:0] m);
      logic [IDX_W-1:0] f = '0;
      for (int k = 0; k < MAC_W / IDX_W; k++) f ^= m[k*IDX_W +: IDX_W];
      return f;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic do_learn(input logic [MAC_W-1:0] m, input logic [PORT_W-1:0] p,
                           input bit exp_fail, input string req);
      @(negedge clk);
      lrn_valid = 1'b1; lrn_mac = m; lrn_port = p;
      @(negedge clk);
      lrn_valid = 1'b0;
      chk(lrn_fail == exp_fail, req, "learn fail", lrn_fail, exp_fail);
   endtask

   task automatic do_lookup(input logic [MAC_W-1:0] m, input bit exp_hit,
                            input logic [PORT_W-1:0] exp_port, input string req);
      @(negedge clk);
      dst_valid = 1'b1; dst_mac = m;
      @(negedge clk);
      dst_valid = 1'b0;
      chk(res_valid && res_hit == exp_hit && res_port == exp_port, req, "lookup hit/port",
          {res_valid, res_hit, res_port}, {1'b1, exp_hit, exp_port});
   endtask

   task automatic mg_write(input bit cam, input int a, input logic [MAC_W-1:0] m,
                           input logic [PORT_W-1:0] p, input bit v, input bit s);
      @(negedge clk);
      mg_en = 1'b1; mg_we = 1'b1; mg_cam = cam; mg_addr = IDX_W'(a);
      mg_wmac = m; mg_wport = p; mg_wvalid = v; mg_wstatic = s;
      @(negedge clk);
      mg_en = 1'b0; mg_we = 1'b0;
   endtask

   task automatic mg_read(input bit cam, input int a);
      @(negedge clk);
      mg_en = 1'b1; mg_we = 1'b0; mg_cam = cam; mg_addr = IDX_W'(a);
      @(negedge clk);
      mg_en = 1'b0;
   endtask

   initial begin : watchdog
      repeat (150_000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      // R10: outputs and every entry clear after reset
      chk(!lrn_fail && !res_valid && !res_hit && res_port == 0 && !mg_rvalid, "R10",
          "outputs after reset", {lrn_fail, res_valid, res_hit}, 0);
      rst_n = 1'b1;
      for (int s = 0; s < DEPTH; s++) begin
         mg_read(1'b0, s);
         chk(!mg_rvalid, "R10", "main entry invalid", mg_rvalid, 0);
      end
      for (int s = 0; s < CAM_N; s++) begin
         mg_read(1'b1, s);
         chk(!mg_rvalid, "R10", "overflow entry invalid", mg_rvalid, 0);
      end
      do_lookup(mk(4'd2, 8'd3), 1'b0, '0, "R3");

      // R1: fill every main slot, then read back by folded index
      for (int s = 0; s < DEPTH; s++) do_learn(mk(4'(s), 8'(s + 1)), PORT_W'(s), 1'b0, "R1");
      for (int s = 0; s < DEPTH; s++) begin
         mg_read(1'b0, fold(mk(4'(s), 8'(s + 1))));
         chk(mg_rvalid && mg_rmac == mk(4'(s), 8'(s + 1)) && mg_rport == PORT_W'(s) &&
             !mg_rstatic && mg_rage, "R1", "main slot contents", mg_rmac, mk(4'(s), 8'(s + 1)));
         do_lookup(mk(4'(s), 8'(s + 1)), 1'b1, PORT_W'(s), "R3");
      end

      // R8 then R2: a collider learned twice uses one overflow entry
      do_learn(mk(4'd3, 8'h40), 4'd8, 1'b0, "R2");
      do_learn(mk(4'd3, 8'h40), 4'd9, 1'b0, "R8");
      mg_read(1'b1, 0);
      chk(mg_rvalid && mg_rmac == mk(4'd3, 8'h40) && mg_rport == 4'd9, "R8",
          "overflow entry 0 refreshed", mg_rport, 9);
      mg_read(1'b1, 1);
      chk(!mg_rvalid, "R8", "no duplicate in entry 1", mg_rvalid, 0);
      for (int k = 1; k < CAM_N; k++) do_learn(mk(4'd3, 8'(8'h40 + k)), PORT_W'(8 + k), 1'b0, "R2");
      for (int k = 1; k < CAM_N; k++) begin
         mg_read(1'b1, k);
         chk(mg_rvalid && mg_rmac == mk(4'd3, 8'(8'h40 + k)), "R2", "lowest free overflow entry",
             mg_rmac, mk(4'd3, 8'(8'h40 + k)));
         do_lookup(mk(4'd3, 8'(8'h40 + k)), 1'b1, PORT_W'(8 + k), "R3");
      end
      do_lookup(mk(4'd3, 8'd4), 1'b1, 4'd3, "R3");

      // R6: slot and overflow store both full
      do_learn(mk(4'd3, 8'h50), 4'd1, 1'b1, "R6");
      @(negedge clk);
      chk(!lrn_fail, "R6", "fail pulse one cycle", lrn_fail, 0);
      do_lookup(mk(4'd3, 8'h50), 1'b0, '0, "R6");
      // R8: refresh of a main entry changes only the port
      do_learn(mk(4'd5, 8'd6), 4'd14, 1'b0, "R8");
      do_lookup(mk(4'd5, 8'd6), 1'b1, 4'd14, "R8");

      // R5 and R4: static main entry written by management
      mg_write(1'b0, 9, mk(4'd9, 8'h77), 4'd13, 1'b1, 1'b1);
      mg_read(1'b0, 9);
      chk(mg_rvalid && mg_rstatic && mg_rport == 4'd13 && mg_rmac == mk(4'd9, 8'h77), "R5",
          "management write main", mg_rmac, mk(4'd9, 8'h77));
      do_learn(mk(4'd9, 8'h77), 4'd1, 1'b0, "R4");
      do_lookup(mk(4'd9, 8'h77), 1'b1, 4'd13, "R4");
      mg_write(1'b1, 2, mk(4'd3, 8'h99), 4'd6, 1'b1, 1'b0);
      mg_read(1'b1, 2);
      chk(mg_rvalid && !mg_rstatic && mg_rport == 4'd6 && mg_rmac == mk(4'd3, 8'h99), "R5",
          "management write overflow", mg_rmac, mk(4'd3, 8'h99));
      do_lookup(mk(4'd3, 8'h99), 1'b1, 4'd6, "R5");

      // R9: learn and management write hit slot 7 on the same edge
      mg_write(1'b0, 7, '0, '0, 1'b0, 1'b0);
      @(negedge clk);
      lrn_valid = 1'b1; lrn_mac = mk(4'd7, 8'h21); lrn_port = 4'd2;
      mg_en = 1'b1; mg_we = 1'b1; mg_cam = 1'b0; mg_addr = 4'd7;
      mg_wmac = mk(4'd7, 8'h31); mg_wport = 4'd11; mg_wvalid = 1'b1; mg_wstatic = 1'b0;
      @(negedge clk);
      lrn_valid = 1'b0; mg_en = 1'b0; mg_we = 1'b0;
      do_lookup(mk(4'd7, 8'h31), 1'b1, 4'd11, "R9");
      mg_read(1'b0, 7);
      chk(mg_rmac == mk(4'd7, 8'h31), "R9", "management write wins", mg_rmac, mk(4'd7, 8'h31));

      // R7: fast aging, two full passes of 20 entries at 3 cycles per step
      fast_age = 1'b1;
      repeat (200) @(negedge clk);
      fast_age = 1'b0;
      do_lookup(mk(4'd0, 8'd1), 1'b0, '0, "R7");
      do_lookup(mk(4'd5, 8'd6), 1'b0, '0, "R7");
      do_lookup(mk(4'd3, 8'h41), 1'b0, '0, "R7");
      do_lookup(mk(4'd9, 8'h77), 1'b1, 4'd13, "R4");
      mg_read(1'b0, 12);
      chk(!mg_rvalid, "R7", "dynamic main entry aged out", mg_rvalid, 0);
      mg_read(1'b0, 9);
      chk(mg_rvalid && mg_rstatic, "R4", "static survives aging", mg_rvalid, 1);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule